// File: doc/BRIEF.md
# Interleaved Two-Channel Word Demultiplexer

This block sits in front of a pair of conversion channels that share a single 14-bit input bus. Words on the bus alternate between the two channels, one word per interface clock cycle, with channel A always leading. The block sorts the stream into a channel A word and a channel B word. Each complete A/B pair reaches two parallel output registers in the same cycle, at a fixed number of cycles after capture.

A divide-by-two phase marks which channel the current bus word belongs to. The synchronous reset holds that phase low, so reset also sets the channel alignment: the first word sampled after reset is released is always taken as channel A. The A word of a pair waits in a staging register until its partner arrives. The pair then moves down a short delay line, so both outputs change together, and a one-cycle strobe marks each update. The whole design runs on the rising edge of a single clock.

Top module: `iq_word_demux`

## Requirements
- R1: While `rst` is sampled high, `ch_a`, `ch_b` and `pair_stb` are zero from the cycle after that edge onward.
- R2: The first word sampled after `rst` is released is taken as channel A, the second as channel B, and the assignment then alternates on every edge.
- R3: Counting edges after reset release from 0, `ch_a` carries the word from edge 2n and `ch_b` the word from edge 2n+1.
- R4: Both channel outputs of a pair change on the same edge, and `pair_stb` is high for exactly the one cycle that follows that edge.
- R5: A pair whose B word is sampled on edge t reaches the outputs on edge t+LATENCY, with LATENCY = 4 by default. The first update after reset is therefore on edge 5, followed by edges 7, 9 and so on.
- R6: Between pair updates, `ch_a` and `ch_b` hold their last values.
- R7: A reset discards any pair or lone A word still in flight. No strobe occurs and the outputs stay zero until the first pair formed after the reset emerges.
- R8: Bus words present while `rst` is high never reach the outputs.
- R9: Words pass through unaltered at full width. A full-scale value of 0x3FFF on one channel and 0x0000 on the other come out exactly separated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock, one bus word per rising edge |
| rst | input | 1 | Synchronous active-high reset and phase alignment |
| din | input | 14 | Shared bus carrying A and B words alternately |
| ch_a | output | 14 | Channel A output register |
| ch_b | output | 14 | Channel B output register |
| pair_stb | output | 1 | One-cycle pulse marking a pair update |

## Verification
The collision that matters is a reset arriving in the same cycle a pair is about to leave the delay line. The reset must win, and it must also drop the half-formed pair sitting in the staging register. The bench raises reset on purpose one cycle before a scheduled update, and also right after a lone A word. In both cases it expects zeroed outputs with no strobe and a fresh A-first alignment. Random short resets scattered through a long random stream repeat the same clash at arbitrary phases, and each output is compared against a model indexed by edges since release.

// File: rtl/iq_word_demux_pkg.sv
package iq_word_demux_pkg;

    // channel tag carried with each captured word
    typedef enum logic {
        SLOT_A = 1'b0,
        SLOT_B = 1'b1
    } slot_e;

endpackage

// File: rtl/iqd_phase.sv
// Divide-by-two phase: names the channel of the word on the bus this edge.
module iqd_phase
    import iq_word_demux_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output slot_e slot
);

    typedef struct packed {
        slot_e slot;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.slot = SLOT_A;
        end else begin
            st_d.slot = (st_q.slot == SLOT_A) ? SLOT_B : SLOT_A;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign slot = st_q.slot;

endmodule

// File: rtl/iqd_pair.sv
// Capture register followed by the pairing stage (A staged until B arrives).
module iqd_pair
    import iq_word_demux_pkg::*;
#(
    parameter int unsigned WORD_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] din,
    input  slot_e             slot,
    output logic              pair_vld,
    output logic [WORD_W-1:0] pair_a,
    output logic [WORD_W-1:0] pair_b
);

    typedef struct packed {
        logic [WORD_W-1:0] cap_word;
        logic              cap_vld;
        slot_e             cap_slot;
        logic [WORD_W-1:0] stage_a;
        logic              stage_ok;
        logic              pair_vld;
        logic [WORD_W-1:0] pair_a;
        logic [WORD_W-1:0] pair_b;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.pair_vld = 1'b0;
        // first stage: sample the bus with its channel tag
        st_d.cap_word = din;
        st_d.cap_slot = slot;
        st_d.cap_vld  = 1'b1;
        // second stage: stage A, release the pair when B follows
        if (st_q.cap_vld) begin
            if (st_q.cap_slot == SLOT_A) begin
                st_d.stage_a  = st_q.cap_word;
                st_d.stage_ok = 1'b1;
            end else if (st_q.stage_ok) begin
                st_d.pair_vld = 1'b1;
                st_d.pair_a   = st_q.stage_a;
                st_d.pair_b   = st_q.cap_word;
                st_d.stage_ok = 1'b0;
            end
        end
        if (rst) begin
            st_d.cap_vld  = 1'b0;
            st_d.stage_ok = 1'b0;
            st_d.pair_vld = 1'b0;
            st_d.cap_word = '0;
            st_d.stage_a  = '0;
            st_d.pair_a   = '0;
            st_d.pair_b   = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pair_vld = st_q.pair_vld;
    assign pair_a   = st_q.pair_a;
    assign pair_b   = st_q.pair_b;

endmodule

// File: rtl/iqd_delay.sv
// Fixed-depth delay line for a formed pair.
module iqd_delay #(
    parameter int unsigned WORD_W = 14,
    parameter int unsigned DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic [WORD_W-1:0] in_a,
    input  logic [WORD_W-1:0] in_b,
    output logic              out_vld,
    output logic [WORD_W-1:0] out_a,
    output logic [WORD_W-1:0] out_b
);

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] a;
        logic [WORD_W-1:0] b;
    } slot_t;

    generate
        if (DEPTH == 0) begin : g_pass
            assign out_vld = in_vld;
            assign out_a   = in_a;
            assign out_b   = in_b;
        end else begin : g_line
            slot_t [DEPTH-1:0] line_d, line_q;

            always_comb begin
                line_d[0].vld = in_vld;
                line_d[0].a   = in_a;
                line_d[0].b   = in_b;
                for (int i = 1; i < int'(DEPTH); i++) begin
                    line_d[i] = line_q[i-1];
                end
                if (rst) begin
                    line_d = '0;
                end
            end

            always_ff @(posedge clk) begin
                line_q <= line_d;
            end

            assign out_vld = line_q[DEPTH-1].vld;
            assign out_a   = line_q[DEPTH-1].a;
            assign out_b   = line_q[DEPTH-1].b;
        end
    endgenerate

endmodule

// File: rtl/iq_word_demux.sv
module iq_word_demux
    import iq_word_demux_pkg::*;
#(
    parameter int unsigned WORD_W  = 14,
    parameter int unsigned LATENCY = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] ch_a,
    output logic [WORD_W-1:0] ch_b,
    output logic              pair_stb
);

    // capture + pairing + output register account for two of the cycles
    localparam int unsigned DLY_DEPTH = (LATENCY >= 2) ? LATENCY - 2 : 0;

    slot_e             slot;
    logic              pr_vld;
    logic [WORD_W-1:0] pr_a;
    logic [WORD_W-1:0] pr_b;
    logic              dl_vld;
    logic [WORD_W-1:0] dl_a;
    logic [WORD_W-1:0] dl_b;

    iqd_phase u_phase (
        .clk  (clk),
        .rst  (rst),
        .slot (slot)
    );

    iqd_pair #(
        .WORD_W (WORD_W)
    ) u_pair (
        .clk      (clk),
        .rst      (rst),
        .din      (din),
        .slot     (slot),
        .pair_vld (pr_vld),
        .pair_a   (pr_a),
        .pair_b   (pr_b)
    );

    iqd_delay #(
        .WORD_W (WORD_W),
        .DEPTH  (DLY_DEPTH)
    ) u_delay (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (pr_vld),
        .in_a    (pr_a),
        .in_b    (pr_b),
        .out_vld (dl_vld),
        .out_a   (dl_a),
        .out_b   (dl_b)
    );

    typedef struct packed {
        logic [WORD_W-1:0] a;
        logic [WORD_W-1:0] b;
        logic              stb;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d     = out_q;
        out_d.stb = dl_vld;
        if (dl_vld) begin
            out_d.a = dl_a;
            out_d.b = dl_b;
        end
        if (rst) begin
            out_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        out_q <= out_d;
    end

    assign ch_a     = out_q.a;
    assign ch_b     = out_q.b;
    assign pair_stb = out_q.stb;

endmodule

// File: rtl/iq_word_demux_chk.sv
module iq_word_demux_chk #(
    parameter int unsigned WORD_W  = 14,
    parameter int unsigned LATENCY = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [WORD_W-1:0] ch_a,
    input logic [WORD_W-1:0] ch_b,
    input logic              pair_stb
);

    localparam int unsigned FIRST_SEEN = LATENCY + 2;
    localparam logic        SEEN_PAR   = 1'(FIRST_SEEN % 2);

    logic [15:0] since_q;
    logic        par_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= '0;
            par_q   <= 1'b0;
        end else begin
            if (since_q < 16'(FIRST_SEEN)) since_q <= since_q + 16'd1;
            par_q <= ~par_q;
        end
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (ch_a == '0 && ch_b == '0 && !pair_stb));

    // R4
    single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        pair_stb |=> !pair_stb);

    // R6
    hold_between_chk: assert property (@(posedge clk) disable iff (rst)
        (!pair_stb && !$past(rst)) |-> ($stable(ch_a) && $stable(ch_b)));

    // R5
    latency_slot_chk: assert property (@(posedge clk) disable iff (rst)
        pair_stb |-> (since_q >= 16'(FIRST_SEEN) && par_q == SEEN_PAR));

endmodule

bind iq_word_demux iq_word_demux_chk #(
    .WORD_W  (WORD_W),
    .LATENCY (LATENCY)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ch_a     (ch_a),
    .ch_b     (ch_b),
    .pair_stb (pair_stb)
);

// File: tb/sim_iq_word_demux.sv
`timescale 1ns/1ps
module sim_iq_word_demux;

    localparam int W   = 14;
    localparam int LAT = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] din = '0;
    logic [W-1:0] ch_a;
    logic [W-1:0] ch_b;
    logic         pair_stb;

    int checks   = 0;
    int failures = 0;
    int ec       = 0;
    int cycles   = 0;
    string ptag  = "";
    logic [W-1:0] hist [0:4095];
    logic [W-1:0] exp_a = '0;
    logic [W-1:0] exp_b = '0;
    logic         exp_s = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    iq_word_demux #(.WORD_W(W), .LATENCY(LAT)) u0 (
        .clk(clk), .rst(rst), .din(din),
        .ch_a(ch_a), .ch_b(ch_b), .pair_stb(pair_stb)
    );

    task automatic cmp(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h edge=%0d", tag, act, exp, ec - 1);
        end
    endtask

    // expected outputs after edge e (edges counted from reset release)
    function automatic bit is_update(input int e);
        return (e >= LAT + 1) && (((e - LAT - 1) % 2) == 0);
    endfunction

    task automatic check_edge(input int e);
        string tag;
        if (is_update(e)) begin
            exp_a = hist[e-LAT-1];
            exp_b = hist[e-LAT];
            exp_s = 1'b1;
        end else begin
            exp_s = 1'b0;
        end
        if (e == LAT + 1)   tag = "R2 R8";
        else if (exp_s)     tag = "R3 R5";
        else if (e < LAT+1) tag = "R7";
        else                tag = "R6";
        cmp({tag, " ", ptag, " ch_a"}, ch_a, exp_a);
        cmp({tag, " ", ptag, " ch_b"}, ch_b, exp_b);
        cmp({"R4 ", ptag, " pair_stb"}, W'(pair_stb), W'(exp_s));
    endtask

    task automatic step(input logic [W-1:0] w);
        din = w;
        if (ec < 4096) hist[ec] = w;
        @(posedge clk);
        ec++;
        @(negedge clk);
        check_edge(ec - 1);
    endtask

    task automatic do_reset(input int n);
        rst = 1'b1;
        for (int i = 0; i < n; i++) begin
            din = W'($urandom);
            @(posedge clk);
            @(negedge clk);
            cmp("R1 ch_a", ch_a, '0);
            cmp("R1 ch_b", ch_b, '0);
            cmp("R1 pair_stb", W'(pair_stb), '0);
        end
        rst   = 1'b0;
        ec    = 0;
        exp_a = '0;
        exp_b = '0;
        exp_s = 1'b0;
    endtask

    initial begin
        while (cycles < 200000) begin
            @(posedge clk);
            cycles++;
        end
        failures++;
        $display("FAIL watchdog act=%0d exp=<200000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        @(negedge clk);
        do_reset(3);

        // R9: constant full scale on A, zero on B
        ptag = "R9";
        for (int i = 0; i < 20; i++) step((i % 2 == 0) ? 14'h3FFF : 14'h0000);

        // ascending ramp on A, descending on B
        ptag = "ramp";
        do_reset(2);
        for (int i = 0; i < 40; i++)
            step((i % 2 == 0) ? W'(i / 2) : W'(14'h3FFF - i / 2));

        // R7: reset one cycle before an update would leave the line
        ptag = "R7 clash";
        for (int i = 0; i < 8; i++) step(W'(14'h1000 + i));
        do_reset(1);
        // R7: lone A word then reset
        step(14'h2AAA);
        do_reset(2);
        for (int i = 0; i < 12; i++) step(W'(14'h0800 + i));

        // random stream with sparse random resets
        ptag = "rand";
        do_reset(1);
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 150) == 0 || ec >= 4000) do_reset(1 + ($urandom % 3));
            step(W'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule